// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block joins a simple request port on the synchronous side of a chip to an external asynchronous static RAM of 2^ADDR_W words of DATA_W bits. A request carries a direction bit, an address and, for writes, a data word. It is taken only while the controller is idle. The controller then drives the memory address bus, the shared data bus and two active-low strobes: a write strobe (`sram_we_n`) and an output-enable strobe (`sram_oe_n`). The output enable sets the direction of the data bus.

A write first presents the address and the data for a setup interval. It then holds the write strobe low for a programmed pulse width. After the strobe rises it keeps address and data steady for a hold interval. A read keeps the write strobe high and lowers the output enable. It waits a programmed access time and then registers the data bus. Each operation ends with a one-cycle `done` pulse. All intervals are whole clock cycles set by parameters, and each is at least 1.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and after it is released, `sram_we_n` and `sram_oe_n` are 1 (deasserted), `done` is 0 and `req_ready` is 1.
- R2: A request is taken only on a rising clock edge where `req_ready` and `req_valid` are both 1. `req_ready` is 1 exactly when the controller is idle, and a `req_valid` raised while busy has no effect.
- R3: For a write (`req_write`=1) taken at edge E, `sram_addr` shows the request address from E on. `sram_we_n` stays 1 for the first SETUP_LEN cycles, where SETUP_LEN = max(ADDR_SETUP, DATA_SETUP). It is then 0 for exactly WR_PULSE cycles, then 1 for WR_HOLD cycles, and the address stays unchanged throughout.
- R4: During a write, the data bus carries the write word in the last DATA_SETUP cycles before `sram_we_n` falls, through the whole strobe pulse, and for the WR_HOLD cycles after it rises.
- R5: For a read (`req_write`=0) taken at edge E, `sram_oe_n` is 0 and `sram_we_n` is 1 for exactly RD_ACCESS cycles. The data bus is registered into `rdata` on the edge that ends the last access cycle.
- R6: `done` is a single-cycle pulse that rises SETUP_LEN+WR_PULSE+WR_HOLD edges after a write is taken, or RD_ACCESS edges after a read is taken. `rdata` then holds its value until the next read completes.
- R7: `sram_we_n` and `sram_oe_n` are never 0 together, and the controller never drives the data bus while `sram_oe_n` is 0.
- R8: The `done` cycle is idle: both strobes are 1 and the bus is released. There is therefore at least one such cycle between any two operations, including a request made in the `done` cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last registered read data |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_dq | inout | DATA_W | Shared memory data bus |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |

## Verification
The assertions assume that nothing outside the block drives the strobes. They also assume that the external memory drives the data bus only while its output enable is low and its write strobe is high. The behavioural memory in the bench keeps to this rule. Its read data turns valid only when the access count has elapsed, and until then it returns the inverted word. Requests change only at falling edges. Each operation starts from idle, either right after reset or in the `done` cycle of the previous one. Busy-time requests are raised only on purpose, to show that they are ignored.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_ACCESS
    } asram_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int ADDR_SETUP = 2,
    parameter int DATA_SETUP = 1,
    parameter int WR_PULSE   = 3,
    parameter int WR_HOLD    = 1,
    parameter int RD_ACCESS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic              capture,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_drive
);

    localparam int SETUP_LEN = imax(ADDR_SETUP, DATA_SETUP);
    localparam int LONGEST   = imax(imax(SETUP_LEN, WR_PULSE), imax(WR_HOLD, RD_ACCESS));
    localparam int CNT_W     = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_LEN - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(WR_HOLD - 1);
    localparam logic [CNT_W-1:0] ACCESS_LAST = CNT_W'(RD_ACCESS - 1);
    localparam logic [CNT_W-1:0] DATA_LEAD   = CNT_W'(DATA_SETUP);

    typedef struct packed {
        asram_state_e      st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_q;

    assign last_q = (seq_q.cnt == '0);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr = req_addr;
                    if (req_write) begin
                        seq_d.wdata = req_wdata;
                        seq_d.st    = ST_SETUP;
                        seq_d.cnt   = SETUP_LAST;
                    end else begin
                        seq_d.st  = ST_ACCESS;
                        seq_d.cnt = ACCESS_LAST;
                    end
                end
            end
            ST_SETUP: begin
                if (last_q) begin
                    seq_d.st  = ST_PULSE;
                    seq_d.cnt = PULSE_LAST;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_PULSE: begin
                if (last_q) begin
                    seq_d.st  = ST_HOLD;
                    seq_d.cnt = HOLD_LAST;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_HOLD, ST_ACCESS: begin
                if (last_q) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.cnt  = '0;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: begin
                seq_d.st  = ST_IDLE;
                seq_d.cnt = '0;
            end
        endcase
        // Strobes and bus enable are registered from the next state.
        seq_d.we_n = (seq_d.st != ST_PULSE);
        seq_d.oe_n = (seq_d.st != ST_ACCESS);
        seq_d.drv  = (seq_d.st == ST_PULSE) || (seq_d.st == ST_HOLD) ||
                     ((seq_d.st == ST_SETUP) && (seq_d.cnt < DATA_LEAD));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, addr: '0, wdata: '0,
                       we_n: 1'b1, oe_n: 1'b1, drv: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign done      = seq_q.done;
    assign capture   = (seq_q.st == ST_ACCESS) && last_q;
    assign mem_addr  = seq_q.addr;
    assign mem_wdata = seq_q.wdata;
    assign mem_we_n  = seq_q.we_n;
    assign mem_oe_n  = seq_q.oe_n;
    assign mem_drive = seq_q.drv;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!seq_q.we_n && !seq_q.oe_n)); // R7
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.oe_n |-> !seq_q.drv); // R7
    AST_DATA_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.we_n) |-> $past(seq_q.drv)); // R4
    AST_DATA_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.we_n) |-> seq_q.drv); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done); // R6
    AST_TAKE_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> (seq_q.we_n && seq_q.oe_n && !seq_q.drv)); // R8

endmodule

// File: rtl/asram_dqio.sv
module asram_dqio #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] dq
);

    logic [DATA_W-1:0] rdata_d, rdata_q;

    assign dq = drive ? wdata : {DATA_W{1'bz}};

    always_comb begin
        rdata_d = rdata_q;
        if (capture) begin
            rdata_d = dq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    AST_HOLD_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata_q)); // R6

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int ADDR_SETUP = 2,
    parameter int DATA_SETUP = 1,
    parameter int WR_PULSE   = 3,
    parameter int WR_HOLD    = 1,
    parameter int RD_ACCESS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq,
    output logic              sram_we_n,
    output logic              sram_oe_n
);

    logic              capture;
    logic              drive;
    logic [DATA_W-1:0] wdata;

    asram_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ADDR_SETUP(ADDR_SETUP),
        .DATA_SETUP(DATA_SETUP),
        .WR_PULSE  (WR_PULSE),
        .WR_HOLD   (WR_HOLD),
        .RD_ACCESS (RD_ACCESS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_ready(req_ready),
        .done     (done),
        .capture  (capture),
        .mem_addr (sram_addr),
        .mem_wdata(wdata),
        .mem_we_n (sram_we_n),
        .mem_oe_n (sram_oe_n),
        .mem_drive(drive)
    );

    asram_dqio #(
        .DATA_W(DATA_W)
    ) u_dqio (
        .clk    (clk),
        .rst_n  (rst_n),
        .drive  (drive),
        .wdata  (wdata),
        .capture(capture),
        .rdata  (rdata),
        .dq     (sram_dq)
    );

    AST_CAPTURE_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (!sram_oe_n && sram_we_n)); // R5

endmodule

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int AS = 3;
    localparam int DS = 2;
    localparam int WP = 3;
    localparam int WH = 2;
    localparam int RA = 4;
    localparam int SL = (AS > DS) ? AS : DS;
    localparam int WLEN = SL + WP + WH;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done, sram_we_n, sram_oe_n;
    logic [DW-1:0] rdata;
    logic [AW-1:0] sram_addr;
    wire  [DW-1:0] sram_dq;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [DW-1:0] last_rd = '0;

    always #4 clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ADDR_SETUP(AS), .DATA_SETUP(DS),
                 .WR_PULSE(WP), .WR_HOLD(WH), .RD_ACCESS(RA)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .sram_addr(sram_addr), .sram_dq(sram_dq),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n));

    function automatic logic [DW-1:0] init_word(input int a);
        return 16'hA5C3 ^ DW'(a * 257);
    endfunction

    // Behavioural memory: data valid only once the access time has run.
    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] shadow [WORDS];
    int            acc_cnt = 0;
    logic          prev_we_n = 1'b1;
    logic [AW-1:0] pend_a;
    logic [DW-1:0] pend_d;

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i]    = init_word(i);
            shadow[i] = init_word(i);
        end
    end

    always @(posedge clk) acc_cnt <= sram_oe_n ? 0 : acc_cnt + 1;

    always @(negedge clk) begin
        if (!sram_we_n) begin
            pend_a = sram_addr;
            pend_d = sram_dq;
        end else if (!prev_we_n) begin
            mem[pend_a] = pend_d;
        end
        prev_we_n = sram_we_n;
    end

    assign sram_dq = (!sram_oe_n && sram_we_n) ?
                     ((acc_cnt >= RA - 1) ? mem[sram_addr] : ~mem[sram_addr]) : 'z;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge with the controller idle; returns at the done-cycle negedge.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] w, input bit noise);
        int addr_err = 0, we_err = 0, dat_err = 0, oe_err = 0, dn_err = 0, rdy_err = 0;
        chk(req_ready == 1'b1, "R2", "ready before write", req_ready, 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = w;
        for (int k = 1; k <= WLEN; k++) begin
            @(negedge clk);
            if (noise) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = ~a;
            end else begin
                req_valid = 1'b0;
            end
            if (sram_addr != a) addr_err++;
            if (sram_we_n != ((k > SL && k <= SL + WP) ? 1'b0 : 1'b1)) we_err++;
            if (k > SL - DS && sram_dq != w) dat_err++;
            if (!sram_oe_n) oe_err++;
            if (done) dn_err++;
            if (req_ready) rdy_err++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(addr_err == 0, "R3", "address held during write", addr_err, 0);
        chk(we_err == 0, "R3", "write strobe shape", we_err, 0);
        chk(dat_err == 0, "R4", "write data window", dat_err, 0);
        chk(oe_err == 0, "R7", "oe low during write", oe_err, 0);
        chk(dn_err == 0, "R6", "done early or repeated", dn_err, 0);
        chk(rdy_err == 0, "R2", "ready while busy", rdy_err, 0);
        chk(done == 1'b1, "R6", "write done pulse", done, 1);
        chk(sram_we_n && sram_oe_n, "R8", "strobes in done cycle", {sram_we_n, sram_oe_n}, 3);
        chk(rdata == last_rd, "R6", "rdata held across write", rdata, last_rd);
        shadow[a] = w;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int addr_err = 0, oe_err = 0, we_err = 0, dn_err = 0;
        chk(req_ready == 1'b1, "R2", "ready before read", req_ready, 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        for (int k = 1; k <= RA; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (sram_addr != a) addr_err++;
            if (sram_oe_n) oe_err++;
            if (!sram_we_n) we_err++;
            if (done) dn_err++;
        end
        @(negedge clk);
        chk(addr_err == 0, "R5", "read address", addr_err, 0);
        chk(oe_err == 0, "R5", "oe low for access time", oe_err, 0);
        chk(we_err == 0, "R7", "we low during read", we_err, 0);
        chk(dn_err == 0, "R6", "done early or repeated", dn_err, 0);
        chk(done == 1'b1, "R6", "read done pulse", done, 1);
        chk(sram_oe_n && sram_we_n, "R8", "strobes in done cycle", {sram_we_n, sram_oe_n}, 3);
        chk(rdata == shadow[a], "R5", "read data", rdata, shadow[a]);
        last_rd = shadow[a];
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        chk(sram_we_n && sram_oe_n && !done, "R1", "strobes in reset",
            {sram_we_n, sram_oe_n, done}, 6);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sram_we_n && sram_oe_n, "R1", "strobes after reset", {sram_we_n, sram_oe_n}, 3);
        chk(!done && req_ready, "R1", "done/ready after reset", {done, req_ready}, 1);

        // Directed: read of untouched word, write, read back, back to back.
        do_read(6'd5);
        do_write(6'd5, 16'h1234, 1'b0);
        do_read(6'd5);
        do_write(6'd63, 16'hFFFF, 1'b0);
        do_write(6'd0, 16'h8001, 1'b0);
        do_read(6'd63);
        do_read(6'd0);

        // Directed: requests raised while busy are ignored.
        do_write(6'd9, 16'h0F0F, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(sram_we_n && sram_oe_n && req_ready && !done, "R2",
                "busy request not taken", {sram_we_n, sram_oe_n, req_ready, done}, 4'b1110);
        end
        do_read(6'd9);
        do_read(6'd54);

        // Random mix.
        for (int n = 0; n < 150; n++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] w;
            a = AW'($urandom);
            w = DW'($urandom);
            if (w == '0) w = 16'h0001;
            if ($urandom % 2 == 0) do_write(a, w, 1'b0);
            else do_read(a);
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                chk(!done, "R6", "done single cycle", done, 0);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule